// File: doc/BRIEF.md
# DMA Logical Address Translator

This block sits between the I/O channels and main memory. It turns a 24-bit logical DMA address into a physical address. Translation uses one table level of 4 KiB pages. Logical bits [23:12] select a table entry, and bits [11:0] pass straight through as the page offset. The table lives in memory at a programmable base address. Each entry is 8 bytes, and only its first 32-bit word, which holds the frame, is used. An eight-entry fully associative cache keeps recent translations on chip.

A channel presents `req_laddr` with `req_valid` and holds both steady until `req_ready` is high. The result on `xl_paddr` and `xl_fault` is valid in exactly the cycle in which `req_valid && req_ready` is true. On a cache hit, or on a limit fault, `req_ready` rises in the same cycle the request appears. On a miss, the block stalls the channel and issues one read on the memory port. `mem_rd_valid` stays high, with a stable address, until `mem_rd_ready` is seen. The single response word arrives later on `mem_rsp_valid`. The response has no ready signal: the block always accepts it. The fetched entry fills the cache, and the request is then served as a hit.

Software uses a small register port. Writes are registered, and reads are combinational from `cfg_addr`. Through it, software sets the table base and the table limit (in bytes), flushes the cache by writing to an invalidate slot, and reads the logical address of the most recent fault.

Top module: `dma_xlate`

## Requirements
- R1: A translation that does not fault returns `xl_paddr` = {bits [28:12] of the entry word, `req_laddr[11:0]`}.
- R2: When the page's entry is cached and the request does not fault, `req_ready` is high in the same cycle as `req_valid`, and no memory read is issued.
- R3: On a miss, `req_ready` stays low. Exactly one read is issued, at `mem_rd_addr` = base + index×8. `mem_rd_valid` and the address are held until `mem_rd_ready`. After the response, the request is served from the fetched entry.
- R4: Bits [11:0] and [31:29] of the fetched entry word do not affect the result.
- R5: If index×8 ≥ limit, the request completes in the same cycle with `xl_fault`=1 and `xl_paddr`=0, and no memory read is issued. This holds even when the page is cached.
- R6: On every faulting handshake, the logical address is captured into the fault-address register.
- R7: Register map by `cfg_addr`: 0 = table base (read/write), 1 = table limit in bytes (read/write), 2 = invalidate (a write of any value; reads as 0), 3 = fault address (read-only; writes are ignored).
- R8: A write to the invalidate slot discards every cached translation, so the next access to any page reads its entry from memory again. Until that write, cached translations stay in use even if the table in memory has changed.
- R9: If an invalidate write arrives while a miss is being fetched, the fetched entry is discarded, and the waiting request fetches its entry again.
- R10: The cache holds 8 entries, replaced round-robin. The replacement pointer restarts at slot 0 after reset and after every invalidate.
- R11: After reset, base, limit and the fault address are 0, so every request faults until a limit is programmed.
- R12: With `req_valid` low, the block issues no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Result valid this cycle; request consumed |
| req_laddr | input | 24 | Logical DMA address |
| xl_paddr | output | 29 | Translated physical address (0 on fault) |
| xl_fault | output | 1 | Index beyond table limit |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | First word of the table entry |

## Verification
Some properties can be checked on every cycle: the offset passes through on each completed translation, a request past the limit always completes as a fault with a zero address, the fault register captures the address after a faulting handshake, and a pending table read keeps its address until it is accepted. Other behaviours need the bench's scenarios against a memory model with a random delay: whether an access hits or misses, and which entry round-robin replacement evicts. These are shown by counting memory reads. The same holds for stale translations surviving until an invalidate, and for a fetch being thrown away when an invalidate lands in the middle of a walk.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {WK_IDLE, WK_ISSUE, WK_WAIT} walk_state_e;

  localparam logic [1:0] CFG_BASE  = 2'd0;
  localparam logic [1:0] CFG_LIMIT = 2'd1;
  localparam logic [1:0] CFG_INVAL = 2'd2;
  localparam logic [1:0] CFG_FAULT = 2'd3;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
  import xlate_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int LA_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             fault_set,
  input  logic [LA_W-1:0]  fault_laddr,
  output logic [REG_W-1:0] tbl_base,
  output logic [REG_W-1:0] tbl_limit,
  output logic [LA_W-1:0]  flt_laddr,
  output logic             inval
);
  assign inval = cfg_we && (cfg_addr == CFG_INVAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base  <= '0;
      tbl_limit <= '0;
      flt_laddr <= '0;
    end else begin
      if (cfg_we && cfg_addr == CFG_BASE)  tbl_base  <= cfg_wdata;
      if (cfg_we && cfg_addr == CFG_LIMIT) tbl_limit <= cfg_wdata;
      if (fault_set)                       flt_laddr <= fault_laddr;
    end
  end

  always_comb begin
    case (cfg_addr)
      CFG_BASE:  cfg_rdata = tbl_base;
      CFG_LIMIT: cfg_rdata = tbl_limit;
      CFG_FAULT: cfg_rdata = {{(REG_W-LA_W){1'b0}}, flt_laddr};
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 12,
  parameter int FRM_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [FRM_W-1:0] lk_frame,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [FRM_W-1:0] fill_frame
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRM_W-1:0]   frame_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
  end

  assign lk_hit = |match;

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_frame = lk_frame | frame_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (flush) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (fill_en) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[ptr_q]   <= fill_tag;
      frame_q[ptr_q] <= fill_frame;
    end
  end
endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
  import xlate_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int IDX_W  = 12,
  parameter int PAGE_W = 12,
  parameter int PA_W   = 29,
  parameter int ENT_LG = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [IDX_W-1:0]     idx,
  input  logic [REG_W-1:0]     tbl_base,
  input  logic                 inval,
  output logic                 busy,
  output logic                 mem_rd_valid,
  input  logic                 mem_rd_ready,
  output logic [REG_W-1:0]     mem_rd_addr,
  input  logic                 mem_rsp_valid,
  input  logic [REG_W-1:0]     mem_rsp_data,
  output logic                 fill_en,
  output logic [IDX_W-1:0]     fill_tag,
  output logic [PA_W-PAGE_W-1:0] fill_frame
);
  walk_state_e st_q;
  logic        stale_q;
  logic [REG_W-1:0] addr_q;
  logic [IDX_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      stale_q <= 1'b0;
      addr_q  <= '0;
      tag_q   <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (start) begin
          st_q    <= WK_ISSUE;
          addr_q  <= tbl_base + {{(REG_W-IDX_W-ENT_LG){1'b0}}, idx, {ENT_LG{1'b0}}};
          tag_q   <= idx;
          stale_q <= 1'b0;
        end
        WK_ISSUE: begin
          if (inval) stale_q <= 1'b1;
          if (mem_rd_ready) st_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (inval) stale_q <= 1'b1;
          if (mem_rsp_valid) st_q <= WK_IDLE;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != WK_IDLE);
  assign mem_rd_valid = (st_q == WK_ISSUE);
  assign mem_rd_addr  = addr_q;
  assign fill_en      = (st_q == WK_WAIT) && mem_rsp_valid && !stale_q && !inval;
  assign fill_tag     = tag_q;
  assign fill_frame   = mem_rsp_data[PA_W-1:PAGE_W];

  wire unused_rsp = ^{mem_rsp_data[REG_W-1:PA_W], mem_rsp_data[PAGE_W-1:0]};
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int REG_W   = 32,
  parameter int LA_W    = 24,
  parameter int PAGE_W  = 12,
  parameter int PA_W    = 29,
  parameter int ENTRIES = 8,
  parameter int ENT_LG  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic [PA_W-1:0]  xl_paddr,
  output logic             xl_fault,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [REG_W-1:0] mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [REG_W-1:0] mem_rsp_data
);
  localparam int IDX_W = LA_W - PAGE_W;
  localparam int FRM_W = PA_W - PAGE_W;

  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] tbl_base, tbl_limit, ent_off;
  logic [LA_W-1:0]  flt_laddr;
  logic             inval, busy, hit, over, start, fill_en;
  logic [FRM_W-1:0] hit_frame, fill_frame;
  logic [IDX_W-1:0] fill_tag;

  assign idx     = req_laddr[LA_W-1:PAGE_W];
  assign ent_off = {{(REG_W-IDX_W-ENT_LG){1'b0}}, idx, {ENT_LG{1'b0}}};
  assign over    = (ent_off >= tbl_limit);

  assign req_ready = !busy && (over || hit);
  assign start     = req_valid && !busy && !over && !hit;
  assign xl_fault  = over;
  assign xl_paddr  = over ? '0 : {hit_frame, req_laddr[PAGE_W-1:0]};

  xlate_regs #(.REG_W(REG_W), .LA_W(LA_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .fault_set(req_valid && req_ready && over), .fault_laddr(req_laddr),
    .tbl_base, .tbl_limit, .flt_laddr, .inval
  );

  xlate_cache #(.ENTRIES(ENTRIES), .TAG_W(IDX_W), .FRM_W(FRM_W)) u_cache (
    .clk, .rst_n, .flush(inval), .lk_tag(idx), .lk_hit(hit),
    .lk_frame(hit_frame), .fill_en, .fill_tag, .fill_frame
  );

  xlate_walk #(.REG_W(REG_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W), .PA_W(PA_W),
               .ENT_LG(ENT_LG)) u_walk (
    .clk, .rst_n, .start, .idx, .tbl_base, .inval, .busy,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
    .fill_en, .fill_tag, .fill_frame
  );
endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk #(
  parameter int REG_W  = 32,
  parameter int LA_W   = 24,
  parameter int PAGE_W = 12,
  parameter int PA_W   = 29,
  parameter int ENT_LG = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LA_W-1:0]  req_laddr,
  input logic [PA_W-1:0]  xl_paddr,
  input logic             xl_fault,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [REG_W-1:0] mem_rd_addr,
  input logic [REG_W-1:0] tbl_limit,
  input logic [LA_W-1:0]  flt_laddr
);
  localparam int IDX_W = LA_W - PAGE_W;
  logic [REG_W-1:0] eoff;
  assign eoff = {{(REG_W-IDX_W-ENT_LG){1'b0}}, req_laddr[LA_W-1:PAGE_W], {ENT_LG{1'b0}}};

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xl_fault |-> xl_paddr[PAGE_W-1:0] == req_laddr[PAGE_W-1:0]);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  // R3
  stall_during_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && req_ready));
  // R5
  limit_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !mem_rd_valid && req_ready && (eoff >= tbl_limit) |-> xl_fault && xl_paddr == '0);
  // R6
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && xl_fault |=> flt_laddr == $past(req_laddr));
endmodule

bind dma_xlate dma_xlate_chk #(.REG_W(REG_W), .LA_W(LA_W), .PAGE_W(PAGE_W), .PA_W(PA_W),
                               .ENT_LG(ENT_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_laddr(req_laddr), .xl_paddr(xl_paddr), .xl_fault(xl_fault),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .tbl_limit(tbl_limit), .flt_laddr(flt_laddr)
);

// File: tb/dma_xlate_tb.sv
`timescale 1ns/1ps
module dma_xlate_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, xl_fault;
  logic [23:0] req_laddr = '0;
  logic [28:0] xl_paddr;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic mem_rd_valid, mem_rd_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rd_addr, mem_rsp_data = 0;

  int checks = 0, fails = 0, rd_count = 0;
  int gen = 0;
  logic [31:0] last_rd_addr = 0, cur_base = 0, cur_limit = 0;

  always #4 clk = ~clk;

  dma_xlate u_dut (.*);

  function automatic logic [31:0] tbl_word(input logic [31:0] a, input int g);
    return (a * 32'h9E37_79B1) ^ (32'(g) * 32'h0123_4567) ^ 32'hE000_0A5A;
  endfunction

  function automatic logic [28:0] exp_pa(input logic [23:0] la);
    logic [31:0] w;
    w = tbl_word(cur_base + {17'd0, la[23:12], 3'd0}, gen);
    return {w[28:12], la[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random accept and response delay
  int mstate = 0, mdelay = 0;
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 0;
    if (mstate == 1) begin
      mem_rd_ready = 0;
      mstate = 2;
      mdelay = 1 + int'($urandom % 3);
    end else if (mstate == 2) begin
      mdelay--;
      if (mdelay == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = tbl_word(last_rd_addr, gen);
        mstate = 0;
      end
    end else if (mem_rd_valid && rst_n) begin
      if ($urandom % 2 == 0) begin
        mem_rd_ready = 1;
        last_rd_addr = mem_rd_addr;
        rd_count++;
        mstate = 1;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a == 0) cur_base = d;
    if (a == 1) cur_limit = d;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic xlate(input logic [23:0] la, output logic [28:0] pa, output logic f,
                       output int wait_cyc);
    @(negedge clk);
    req_valid = 1; req_laddr = la; wait_cyc = 0;
    #1;
    while (!req_ready && wait_cyc < 1000) begin
      @(negedge clk); #1; wait_cyc++;
    end
    pa = xl_paddr; f = xl_fault;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic expect_ok(input logic [23:0] la, input string req, input int exp_reads);
    logic [28:0] pa; logic f; int w, r0;
    r0 = rd_count;
    xlate(la, pa, f, w);
    chk(!f && pa == exp_pa(la), req, {3'b0, pa}, {3'b0, exp_pa(la)});
    if (exp_reads >= 0) chk(rd_count - r0 == exp_reads, req, rd_count - r0, exp_reads);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d; logic [28:0] pa; logic f; int w, r0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11 reset values
    cfg_read(0, d); chk(d == 0, "R11 base", d, 0);
    cfg_read(1, d); chk(d == 0, "R11 limit", d, 0);
    cfg_read(3, d); chk(d == 0, "R11 fault addr", d, 0);
    r0 = rd_count;
    xlate(24'h00_1234, pa, f, w);
    chk(f && pa == 0 && w == 0, "R11 fault after reset", {f, 3'b0, pa}, 32'h8000_0000);
    chk(rd_count == r0, "R5 no read on fault", rd_count - r0, 0);
    cfg_read(3, d); chk(d == 32'h1234, "R6 fault addr", d, 32'h1234);

    // R12 idle: no read
    r0 = rd_count;
    repeat (10) @(negedge clk);
    chk(!mem_rd_valid && rd_count == r0, "R12 idle", rd_count - r0, 0);

    // R7 register map
    cfg_write(0, 32'h0010_0008); cfg_write(1, 32'h0000_0400);
    cfg_read(0, d); chk(d == 32'h0010_0008, "R7 base", d, 32'h0010_0008);
    cfg_read(1, d); chk(d == 32'h400, "R7 limit", d, 32'h400);
    cfg_read(2, d); chk(d == 0, "R7 inval reads 0", d, 0);
    cfg_write(3, 32'hDEAD); cfg_read(3, d);
    chk(d == 32'h1234, "R7 fault addr read-only", d, 32'h1234);

    // R3 miss, R1/R4 result, R2 hit
    expect_ok(24'h00_5ABC, "R3 miss fetch", 1);
    chk(last_rd_addr == 32'h0010_0008 + 5 * 8, "R3 read address", last_rd_addr, 32'h0010_0030);
    r0 = rd_count;
    xlate(24'h00_5001, pa, f, w);
    chk(w == 0 && rd_count == r0, "R2 hit same cycle", w, 0);
    chk(pa == exp_pa(24'h00_5001), "R1 R4 translation", {3'b0, pa}, {3'b0, exp_pa(24'h00_5001)});

    // R5 boundary: idx 127 valid, 128 faults
    expect_ok(24'h07_F00F, "R5 last valid index", 1);
    r0 = rd_count;
    xlate(24'h08_0123, pa, f, w);
    chk(f && pa == 0 && rd_count == r0, "R5 first index past limit", {f, 3'b0, pa}, 32'h8000_0000);
    cfg_read(3, d); chk(d == 32'h08_0123, "R6 fault addr update", d, 32'h08_0123);
    // R5 fault over a cached entry
    cfg_write(1, 32'h28);  // 5*8: idx 5 now out of range
    xlate(24'h00_5ABC, pa, f, w);
    chk(f && pa == 0, "R5 fault over cached entry", {f, 3'b0, pa}, 32'h8000_0000);
    cfg_write(1, 32'h400);

    // R8 stale entry until invalidate
    gen = 1;
    r0 = rd_count;
    xlate(24'h00_5ABC, pa, f, w);
    gen = 0;
    chk(pa == exp_pa(24'h00_5ABC) && rd_count == r0, "R8 cached before invalidate",
        {3'b0, pa}, {3'b0, exp_pa(24'h00_5ABC)});
    gen = 1;
    cfg_write(2, 32'h0);
    expect_ok(24'h00_5ABC, "R8 refetch after invalidate", 1);

    // R9 invalidate during walk
    r0 = rd_count;
    fork
      xlate(24'h00_9010, pa, f, w);
      begin @(negedge clk); @(negedge clk); cfg_write(2, 32'h1); end
    join
    chk(!f && pa == exp_pa(24'h00_9010), "R9 result", {3'b0, pa}, {3'b0, exp_pa(24'h00_9010)});
    chk(rd_count - r0 == 2, "R9 refetch count", rd_count - r0, 2);

    // R10 round-robin with eight slots
    cfg_write(2, 32'h0);
    for (int i = 0; i < 8; i++) expect_ok(24'(((i + 16) << 12) | 7), "R10 fill", 1);
    for (int i = 0; i < 8; i++) expect_ok(24'(((i + 16) << 12) | 9), "R10 all hit", 0);
    expect_ok(24'h01_8000, "R10 ninth page", 1);
    expect_ok(24'h01_1000, "R10 slot 1 kept", 0);
    expect_ok(24'h01_0000, "R10 slot 0 evicted", 1);

    // random mix against the model
    cfg_write(0, 32'h0020_0000); cfg_write(1, 32'h200); cfg_write(2, 0);
    for (int n = 0; n < 300; n++) begin
      logic [23:0] la;
      la = {12'($urandom % 80), 12'($urandom)};
      xlate(la, pa, f, w);
      if ({17'd0, la[23:12], 3'd0} >= cur_limit)
        chk(f && pa == 0, "R5 random fault", {f, 3'b0, pa}, 32'h8000_0000);
      else
        chk(!f && pa == exp_pa(la), "R1 random", {3'b0, pa}, {3'b0, exp_pa(la)});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule